// File: doc/BRIEF.md
# CAN operating-mode sequencer

This block is the top-level mode controller of a CAN protocol core. It tracks which of seven operating modes the core is in: standby, wake-up, resynchronization, idle, transmission, reception or error. It moves between them in response to a software run control, the sampled bus level with its bit-time strobe, a transmit request, and status pulses from the frame engine. Bit timing, frame coding, CRC and the error counters live elsewhere and only reach this block as pulses and flags.

In standby the core gates off its bit-timing clocks and watches only for a dominant level on the bus, which can raise a wake-up interrupt. When software sets run again, the block can optionally drive one dominant bit to wake the other nodes. It then waits for the bus to go quiet before it accepts frames. That takes one run of 11 recessive bits in fast mode, or 128 such runs otherwise and always while the node is bus-off.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the mode is standby and run status, clock enable and dominant drive are all 0. The mode encoding is standby=0, wake-up=1, resync=2, idle=3, transmit=4, receive=5, error=6.
- R2: With run low, wake-up, resync and idle enter standby at the next clock edge. Run status and clock enable are 0 in standby and 1 in every other mode.
- R3: Clearing run during transmit or receive does not cut the frame short. The mode stays put, and a transmit-OK or receive-OK then leads to standby instead of idle.
- R4: In standby with the interrupt enable set, a change of bus_rx_i from 1 (recessive) to 0 (dominant) gives a one-cycle wake_irq_o pulse one cycle later. With the enable clear, or outside standby, no pulse occurs.
- R5: From standby, run high moves to wake-up when the pulse enable is set, otherwise to resync.
- R6: In wake-up the dominant drive rises at the first bit strobe and falls at the second, when the mode becomes resync. It therefore lasts exactly one bit time.
- R7: With fast sync set and bus-off clear, resync moves to idle on the 11th consecutive recessive bit strobe.
- R8: Otherwise resync needs 128 completed runs of 11 recessive bits. A dominant bit restarts only the run in progress; runs already completed are kept.
- R9: In idle, a start-of-frame pulse enters receive and a transmit request enters transmit. When both arrive together, start of frame wins.
- R10: In transmit, the priority is: error goes to error, then arbitration lost goes to receive, then OK goes to idle. In receive, error goes to error, then OK goes to idle.
- R11: Bus-off in transmit, receive or error moves to resync and overrides every frame pulse.
- R12: In error, the error-frame-done pulse leads to idle, or to standby when run is low.
- R13: Resync counting advances only on a bit strobe; cycles without a strobe leave the count and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Software run control |
| wake_pulse_en_i | input | 1 | Send a dominant wake-up bit when leaving standby |
| fast_sync_i | input | 1 | Resync after a single 11-bit recessive run |
| bus_off_i | input | 1 | Node is bus-off |
| sc_irq_en_i | input | 1 | Enable for the standby wake-up interrupt |
| bus_rx_i | input | 1 | Sampled bus level, 1 = recessive |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| tx_req_i | input | 1 | Write of the last transmit data byte |
| sof_i | input | 1 | Start of frame detected |
| arb_lost_i | input | 1 | Arbitration lost |
| tx_ok_i | input | 1 | Transmission completed |
| tx_err_i | input | 1 | Transmission error |
| rx_ok_i | input | 1 | Reception completed |
| rx_err_i | input | 1 | Reception error |
| err_done_i | input | 1 | Error frame completed |
| mode_o | output | 3 | Current mode |
| run_stat_o | output | 1 | Run status readback, 0 in standby |
| drive_dom_o | output | 1 | Request to drive the bus dominant |
| clk_en_o | output | 1 | Enable for the bit-timing and prescaler clocks |
| wake_irq_o | output | 1 | Wake-up interrupt pulse |

## Verification
The properties assume the frame engine sends status pulses only in the modes where they make sense, and that the bit strobe lasts a single cycle. The stimulus respects both assumptions. Pulses are raised for exactly one cycle, only after the bench has confirmed the expected mode, and are cleared before the next check. The bit strobe is always one cycle wide and is separated by at least one idle cycle in the long resync run. Bus level changes in standby are applied without strobes, because the bit-timing clock is off in that mode.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_WAKEUP  = 3'd1,
        MD_RESYNC  = 3'd2,
        MD_IDLE    = 3'd3,
        MD_TX      = 3'd4,
        MD_RX      = 3'd5,
        MD_ERROR   = 3'd6
    } mode_t;

    typedef struct packed {
        logic sof;
        logic arb_lost;
        logic tx_ok;
        logic tx_err;
        logic rx_ok;
        logic rx_err;
        logic err_done;
    } frame_evt_t;

    localparam int unsigned DEF_RUN_BITS = 11;
    localparam int unsigned DEF_RUN_SEQS = 128;

    // Where a completed frame leaves the machine
    function automatic mode_t after_frame(input logic run);
        return run ? MD_IDLE : MD_STANDBY;
    endfunction

endpackage

// File: rtl/can_rec_counter.sv
module can_rec_counter #(
    parameter int unsigned RUN_BITS = 11,
    parameter int unsigned RUN_SEQS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bit_tick,
    input  logic bus_rx,
    input  logic fast,
    output logic done
);
    localparam int unsigned BW = $clog2(RUN_BITS + 1);
    localparam int unsigned SW = $clog2(RUN_SEQS + 1);

    logic [BW-1:0] bit_cnt;
    logic [SW-1:0] seq_cnt;
    logic          run_end;

    assign run_end = active && bit_tick && bus_rx && (bit_cnt == BW'(RUN_BITS - 1));
    assign done    = run_end && (fast || (seq_cnt == SW'(RUN_SEQS - 1)));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt <= '0;
            seq_cnt <= '0;
        end else if (bit_tick) begin
            if (!bus_rx) begin
                bit_cnt <= '0;              // dominant: restart current run only
            end else if (run_end) begin
                bit_cnt <= '0;
                seq_cnt <= seq_cnt + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic irq_en,
    input  logic bus_rx,
    output logic irq
);
    logic prev_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_rx <= 1'b1;
            irq     <= 1'b0;
        end else begin
            prev_rx <= bus_rx;
            irq     <= standby && irq_en && prev_rx && !bus_rx;
        end
    end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       wake_en,
    input  logic       bus_off,
    input  logic       bit_tick,
    input  logic       tx_req,
    input  frame_evt_t evt,
    input  logic       resync_done,
    output mode_t      mode,
    output logic       drive_dom
);
    mode_t nxt;
    logic  wk_armed;

    always_comb begin
        nxt = mode;
        unique case (mode)
            MD_STANDBY: if (run) nxt = wake_en ? MD_WAKEUP : MD_RESYNC;
            MD_WAKEUP: begin
                if (!run)                       nxt = MD_STANDBY;
                else if (bit_tick && wk_armed)  nxt = MD_RESYNC;
            end
            MD_RESYNC: begin
                if (!run)             nxt = MD_STANDBY;
                else if (resync_done) nxt = MD_IDLE;
            end
            MD_IDLE: begin
                if (!run)         nxt = MD_STANDBY;
                else if (evt.sof) nxt = MD_RX;
                else if (tx_req)  nxt = MD_TX;
            end
            MD_TX: begin
                if (bus_off)           nxt = MD_RESYNC;
                else if (evt.tx_err)   nxt = MD_ERROR;
                else if (evt.arb_lost) nxt = MD_RX;
                else if (evt.tx_ok)    nxt = after_frame(run);
            end
            MD_RX: begin
                if (bus_off)         nxt = MD_RESYNC;
                else if (evt.rx_err) nxt = MD_ERROR;
                else if (evt.rx_ok)  nxt = after_frame(run);
            end
            MD_ERROR: begin
                if (bus_off)           nxt = MD_RESYNC;
                else if (evt.err_done) nxt = after_frame(run);
            end
            default: nxt = MD_STANDBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MD_STANDBY;
            wk_armed <= 1'b0;
        end else begin
            mode     <= nxt;
            wk_armed <= (nxt == MD_WAKEUP) && (wk_armed || bit_tick);
        end
    end

    assign drive_dom = (mode == MD_WAKEUP) && wk_armed;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int unsigned RUN_BITS = DEF_RUN_BITS,
    parameter int unsigned RUN_SEQS = DEF_RUN_SEQS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       wake_pulse_en_i,
    input  logic       fast_sync_i,
    input  logic       bus_off_i,
    input  logic       sc_irq_en_i,
    input  logic       bus_rx_i,
    input  logic       bit_tick_i,
    input  logic       tx_req_i,
    input  logic       sof_i,
    input  logic       arb_lost_i,
    input  logic       tx_ok_i,
    input  logic       tx_err_i,
    input  logic       rx_ok_i,
    input  logic       rx_err_i,
    input  logic       err_done_i,
    output logic [2:0] mode_o,
    output logic       run_stat_o,
    output logic       drive_dom_o,
    output logic       clk_en_o,
    output logic       wake_irq_o
);
    mode_t      mode;
    frame_evt_t evt;
    logic       resync_done;
    logic       fast_ok;

    assign evt = '{sof: sof_i, arb_lost: arb_lost_i, tx_ok: tx_ok_i, tx_err: tx_err_i,
                   rx_ok: rx_ok_i, rx_err: rx_err_i, err_done: err_done_i};
    assign fast_ok = fast_sync_i && !bus_off_i;

    can_rec_counter #(.RUN_BITS(RUN_BITS), .RUN_SEQS(RUN_SEQS)) i_rec (
        .clk(clk), .rst(rst), .active(mode == MD_RESYNC), .bit_tick(bit_tick_i),
        .bus_rx(bus_rx_i), .fast(fast_ok), .done(resync_done)
    );

    can_wake_detect i_wake (
        .clk(clk), .rst(rst), .standby(mode == MD_STANDBY), .irq_en(sc_irq_en_i),
        .bus_rx(bus_rx_i), .irq(wake_irq_o)
    );

    can_mode_fsm i_fsm (
        .clk(clk), .rst(rst), .run(run_i), .wake_en(wake_pulse_en_i), .bus_off(bus_off_i),
        .bit_tick(bit_tick_i), .tx_req(tx_req_i), .evt(evt), .resync_done(resync_done),
        .mode(mode), .drive_dom(drive_dom_o)
    );

    assign mode_o     = mode;
    assign run_stat_o = (mode != MD_STANDBY);
    assign clk_en_o   = (mode != MD_STANDBY);
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk
    import can_mode_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       run_i,
    input logic       wake_pulse_en_i,
    input logic       bus_off_i,
    input logic       sc_irq_en_i,
    input logic       bit_tick_i,
    input logic       sof_i,
    input logic       arb_lost_i,
    input logic       tx_ok_i,
    input logic       tx_err_i,
    input logic       rx_ok_i,
    input logic       rx_err_i,
    input logic [2:0] mode_o,
    input logic       drive_dom_o,
    input logic       wake_irq_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> mode_o == MD_STANDBY);

    // R6
    drive_only_wakeup_chk: assert property (@(posedge clk) disable iff (rst)
        drive_dom_o |-> mode_o == MD_WAKEUP);

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_TX && !run_i && !bus_off_i && !tx_err_i && !arb_lost_i && !tx_ok_i)
        |=> mode_o == MD_TX);

    // R4
    wake_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_irq_o) |-> ($past(mode_o) == MD_STANDBY) && $past(sc_irq_en_i));

    // R5
    leave_standby_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_STANDBY && run_i) |=> mode_o == (wake_pulse_en_i ? MD_WAKEUP : MD_RESYNC) || $past(wake_pulse_en_i) && mode_o == MD_WAKEUP || !$past(wake_pulse_en_i) && mode_o == MD_RESYNC);

    // R13
    resync_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_RESYNC && run_i && !bit_tick_i) |=> mode_o == MD_RESYNC);

    // R9
    idle_sof_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_IDLE && run_i && sof_i) |=> mode_o == MD_RX);

    // R11
    bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == MD_TX || mode_o == MD_RX || mode_o == MD_ERROR) && bus_off_i)
        |=> mode_o == MD_RESYNC);

    // R10
    rx_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_RX && run_i && !bus_off_i && !rx_err_i && rx_ok_i) |=> mode_o == MD_IDLE);
endmodule

bind can_mode_seq can_mode_seq_chk i_chk (
    .clk(clk), .rst(rst), .run_i(run_i), .wake_pulse_en_i(wake_pulse_en_i),
    .bus_off_i(bus_off_i), .sc_irq_en_i(sc_irq_en_i), .bit_tick_i(bit_tick_i),
    .sof_i(sof_i), .arb_lost_i(arb_lost_i), .tx_ok_i(tx_ok_i), .tx_err_i(tx_err_i),
    .rx_ok_i(rx_ok_i), .rx_err_i(rx_err_i), .mode_o(mode_o), .drive_dom_o(drive_dom_o),
    .wake_irq_o(wake_irq_o)
);

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;
    localparam int ST = 0, WK = 1, RS = 2, ID = 3, TX = 4, RX = 5, ER = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_i = 0, wake_pulse_en_i = 0, fast_sync_i = 0, bus_off_i = 0, sc_irq_en_i = 0;
    logic bus_rx_i = 1, bit_tick_i = 0, tx_req_i = 0, sof_i = 0, arb_lost_i = 0;
    logic tx_ok_i = 0, tx_err_i = 0, rx_ok_i = 0, rx_err_i = 0, err_done_i = 0;
    logic [2:0] mode_o;
    logic run_stat_o, drive_dom_o, clk_en_o, wake_irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    can_mode_seq i_can_mode_seq (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick(input logic lvl);
        bus_rx_i = lvl;
        bit_tick_i = 1'b1;
        @(negedge clk);
        bit_tick_i = 1'b0;
    endtask

    task automatic clear_evts();
        tx_req_i = 0; sof_i = 0; arb_lost_i = 0; tx_ok_i = 0; tx_err_i = 0;
        rx_ok_i = 0; rx_err_i = 0; err_done_i = 0; bus_off_i = 0;
    endtask

    task automatic reset_dut();
        clear_evts();
        run_i = 0; wake_pulse_en_i = 0; fast_sync_i = 0; sc_irq_en_i = 0; bus_rx_i = 1;
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic go_idle();
        reset_dut();
        run_i = 1; fast_sync_i = 1;
        step();
        for (int i = 0; i < 11; i++) tick(1'b1);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            report();
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(); step(); step();
        check("R1 mode", mode_o, ST);
        check("R1 run_stat", run_stat_o, 0);
        check("R1 clk_en", clk_en_o, 0);
        check("R1 drive", drive_dom_o, 0);
        rst = 0;

        // R4 wake-up interrupt in standby
        sc_irq_en_i = 1; step();
        bus_rx_i = 0; step();
        check("R4 irq pulse", wake_irq_o, 1);
        step();
        check("R4 irq one cycle", wake_irq_o, 0);
        sc_irq_en_i = 0; bus_rx_i = 1; step();
        bus_rx_i = 0; step();
        check("R4 irq disabled", wake_irq_o, 0);
        bus_rx_i = 1;

        // R5/R7 fast resync path
        reset_dut();
        run_i = 1; fast_sync_i = 1; step();
        check("R5 to resync", mode_o, RS);
        check("R2 run_stat", run_stat_o, 1);
        check("R2 clk_en", clk_en_o, 1);
        for (int i = 0; i < 10; i++) tick(1'b1);
        check("R7 before 11th", mode_o, RS);
        tick(1'b1);
        check("R7 idle at 11th", mode_o, ID);

        // R4 no interrupt outside standby; R13 no tick keeps idle
        sc_irq_en_i = 1; step();
        bus_rx_i = 0; step(); step();
        check("R4 irq outside standby", wake_irq_o, 0);
        bus_rx_i = 1; sc_irq_en_i = 0;

        // R2 run cleared in idle
        run_i = 0; step();
        check("R2 idle to standby", mode_o, ST);
        check("R2 run_stat standby", run_stat_o, 0);

        // R5/R6 wake-up pulse
        reset_dut();
        run_i = 1; wake_pulse_en_i = 1; step();
        check("R5 to wakeup", mode_o, WK);
        check("R6 no drive before tick", drive_dom_o, 0);
        step();
        check("R6 waits for tick", drive_dom_o, 0);
        tick(1'b1);
        check("R6 drive on", drive_dom_o, 1);
        step(); step();
        check("R6 drive held", drive_dom_o, 1);
        check("R6 still wakeup", mode_o, WK);
        tick(1'b1);
        check("R6 drive off", drive_dom_o, 0);
        check("R6 to resync", mode_o, RS);
        run_i = 0; step();
        check("R2 resync to standby", mode_o, ST);

        // R9 idle sweep
        for (int v = 0; v < 4; v++) begin
            go_idle();
            sof_i = v[0]; tx_req_i = v[1];
            step(); clear_evts();
            check("R9 idle event", mode_o, v[0] ? RX : (v[1] ? ID + 1 : ID));
        end

        // R10/R11 transmit sweep
        for (int v = 0; v < 16; v++) begin
            int exp;
            go_idle();
            tx_req_i = 1; step(); clear_evts();
            bus_off_i = v[3]; tx_err_i = v[2]; arb_lost_i = v[1]; tx_ok_i = v[0];
            step(); clear_evts();
            exp = v[3] ? RS : v[2] ? ER : v[1] ? RX : v[0] ? ID : TX;
            check(v[3] ? "R11 tx bus-off" : "R10 tx event", mode_o, exp);
        end

        // R10/R11 receive sweep
        for (int v = 0; v < 8; v++) begin
            int exp;
            go_idle();
            sof_i = 1; step(); clear_evts();
            bus_off_i = v[2]; rx_err_i = v[1]; rx_ok_i = v[0];
            step(); clear_evts();
            exp = v[2] ? RS : v[1] ? ER : v[0] ? ID : RX;
            check(v[2] ? "R11 rx bus-off" : "R10 rx event", mode_o, exp);
        end

        // R12 error exits
        go_idle();
        tx_req_i = 1; step(); clear_evts();
        tx_err_i = 1; step(); clear_evts();
        step();
        check("R12 error held", mode_o, ER);
        err_done_i = 1; step(); clear_evts();
        check("R12 error to idle", mode_o, ID);
        sof_i = 1; step(); clear_evts();
        rx_err_i = 1; step(); clear_evts();
        run_i = 0; step();
        check("R12 error held run low", mode_o, ER);
        err_done_i = 1; step(); clear_evts();
        check("R12 error to standby", mode_o, ST);
        go_idle();
        sof_i = 1; step(); clear_evts();
        rx_err_i = 1; step(); clear_evts();
        bus_off_i = 1; err_done_i = 1; step(); clear_evts();
        check("R11 error bus-off", mode_o, RS);

        // R3 frame completes before standby
        go_idle();
        tx_req_i = 1; step(); clear_evts();
        run_i = 0; step(); step(); step();
        check("R3 tx held", mode_o, TX);
        tx_ok_i = 1; step(); clear_evts();
        check("R3 tx to standby", mode_o, ST);
        go_idle();
        sof_i = 1; step(); clear_evts();
        run_i = 0; step(); step();
        check("R3 rx held", mode_o, RX);
        rx_ok_i = 1; step(); clear_evts();
        check("R3 rx to standby", mode_o, ST);

        // R8/R13 slow resync: fast requested but bus-off forces slow path
        reset_dut();
        run_i = 1; fast_sync_i = 1; step();
        bus_off_i = 1;
        for (int i = 0; i < 22; i++) begin tick(1'b1); step(); end
        check("R8 bus-off ignores fast", mode_o, RS);
        for (int i = 0; i < 5; i++) begin tick(1'b1); step(); end
        tick(1'b0); step();
        for (int i = 0; i < 126 * 11 - 1; i++) begin tick(1'b1); step(); end
        check("R13 no exit without tick", mode_o, RS);
        check("R8 before last run ends", mode_o, RS);
        tick(1'b1);
        check("R8 idle after 128 runs", mode_o, ID);
        bus_off_i = 0;

        finished = 1;
        report();
        $finish;
    end
endmodule